// File: doc/BRIEF.md
# Bus Error Exception Frame Sequencer

This block takes over the memory port when a memory cycle has faulted. It saves the state of the fault on the supervisor stack as a 29-word exception frame, then hands the processor a new program counter, a new status register and a new stack pointer. The frame is written one 16-bit word per accepted memory request. Each request is held until the memory acknowledges it or reports an error.

A fault is reported by pulsing `flt_valid` together with its description: the direction, the access size, whether it was an instruction fetch, the address, and the data being written. The same pulse captures the current PC, SR and SP. The sequencer first reads the handler address as two words from the bus-error vector location. It then pushes the frame from the original SP downward and finally pulses `done` with the results.

A second fault that arrives while the sequencer is working puts it in a sticky halted state, and so does an error on any of its own memory cycles. Only reset leaves that state.

Top module: `berr_frame_seq`

## Requirements
- R1: After reset `mem_req`, `done`, `busy` and `halted` are all 0.
- R2: Before any write, the block reads the handler address with two word reads: the high half at byte address 8, then the low half at 10. The result appears as `new_pc` = {high, low}.
- R3: Exactly 29 word writes are made, all at even addresses between SP0-58 and SP0-2 (SP0 = captured SP), and `new_sp` = SP0-58.
- R4: The frame is laid out by byte offset from `new_sp` as follows. +0 holds the original SR. +2 and +4 hold the PC high and low halves. +6 holds 0x8002. +8 holds the status word. +10 and +12 hold the 32-bit zero-extended fault address, high half first. +16 holds the write data. Every other offset up to +56 holds 0.
- R5: The status word has bit 8 = write, bit 9 = byte access, bit 10 = fault address bit 0, bit 13 = instruction fetch, and every other bit 0.
- R6: A 32-bit push is issued as two writes. The high half goes first, at the lower address. The first write lands at SP0-4 and the second at SP0-2.
- R7: `new_sr` = captured SR with bit 13 (0x2000) set, while the frame keeps the unmodified SR.
- R8: Only one request is outstanding at a time, and it stays unchanged until it is acknowledged. With every request acknowledged after W wait cycles, `done` rises 31×(W+1) cycles after the edge that samples `flt_valid`. `done` lasts one cycle.
- R9: An error on any frame write sets `halted`, drops `mem_req` and suppresses `done`.
- R10: An error on a vector read sets `halted` before any write is made.
- R11: A new `flt_valid` while `busy` sets `halted` (nested fault).
- R12: While halted, `flt_valid` is ignored: no request is made and `halted` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | One-cycle fault report |
| flt_write | input | 1 | Faulted cycle was a write |
| flt_byte | input | 1 | Faulted cycle was a byte access |
| flt_ifetch | input | 1 | Faulted cycle was an instruction fetch |
| flt_addr | input | AW | Faulted address |
| flt_wdata | input | 16 | Data of the faulted write |
| cpu_pc | input | 32 | Current program counter |
| cpu_sr | input | 16 | Current status register |
| cpu_sp | input | AW | Current supervisor stack pointer |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with ack |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Request faulted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Double fault, sticky until reset |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Status register with supervisor bit set |
| new_sp | output | AW | Stack pointer after the frame |

## Verification
Every memory response is given on the falling edge and is consumed at the next rising edge. Each word therefore costs W+1 cycles, and `done` is due exactly 31×(W+1) cycles after the sampling edge. The bench counts whole cycles from that edge and compares the count at the first falling edge where `done` or `halted` shows. Frame contents, `new_pc`, `new_sr` and `new_sp` are read one half cycle after the `done` edge, and the frame is read from the bench's memory model rather than from the design. Halting faults are checked at the falling edge right after the error or nested fault is consumed, and again some cycles later, to confirm that nothing moved.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int FRAME_WORDS = 29;
  localparam int IDX_W = $clog2(FRAME_WORDS);

  // kind of one frame word: stand-alone word, high or low half of a long
  typedef enum logic [1:0] {WK_SGL, WK_LHI, WK_LLO} wkind_e;

  typedef enum logic [2:0] {S_IDLE, S_VHI, S_VLO, S_PUSH, S_HALT} seq_st_e;
endpackage

// File: rtl/berr_ssw_enc.sv
module berr_ssw_enc #(
  parameter int WR_BIT  = 8,
  parameter int BY_BIT  = 9,
  parameter int A0_BIT  = 10,
  parameter int IF_BIT  = 13
) (
  input  logic        is_write,
  input  logic        is_byte,
  input  logic        addr_b0,
  input  logic        is_ifetch,
  output logic [15:0] ssw
);
  always_comb begin
    ssw = '0;
    ssw[WR_BIT] = is_write;
    ssw[BY_BIT] = is_byte;
    ssw[A0_BIT] = addr_b0;
    ssw[IF_BIT] = is_ifetch;
  end
endmodule

// File: rtl/berr_frame_word.sv
module berr_frame_word
  import berr_pkg::*;
#(
  parameter logic [15:0] FMT_VEC = 16'h8002
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      ssw,
  input  logic [15:0]      wdata,
  input  logic [31:0]      faddr,
  input  logic [31:0]      pc,
  input  logic [15:0]      sr,
  output wkind_e           kind,
  output logic [15:0]      data
);
  // time order of words: 8 zero longs, 6 buffer words, fault address,
  // status word, format word, PC, SR
  always_comb begin
    kind = WK_SGL;
    data = '0;
    if (idx < IDX_W'(16)) begin
      kind = idx[0] ? WK_LLO : WK_LHI;
    end else begin
      case (idx)
        IDX_W'(20): data = wdata;
        IDX_W'(22): begin kind = WK_LHI; data = faddr[31:16]; end
        IDX_W'(23): begin kind = WK_LLO; data = faddr[15:0];  end
        IDX_W'(24): data = ssw;
        IDX_W'(25): data = FMT_VEC;
        IDX_W'(26): begin kind = WK_LHI; data = pc[31:16]; end
        IDX_W'(27): begin kind = WK_LLO; data = pc[15:0];  end
        IDX_W'(28): data = sr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/berr_frame_seq.sv
module berr_frame_seq
  import berr_pkg::*;
#(
  parameter int              AW       = 24,
  parameter logic [AW-1:0]   VEC_ADDR = AW'(8),
  parameter logic [15:0]     FMT_VEC  = 16'h8002,
  parameter logic [15:0]     SUP_MASK = 16'h2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flt_valid,
  input  logic          flt_write,
  input  logic          flt_byte,
  input  logic          flt_ifetch,
  input  logic [AW-1:0] flt_addr,
  input  logic [15:0]   flt_wdata,
  input  logic [31:0]   cpu_pc,
  input  logic [15:0]   cpu_sr,
  input  logic [AW-1:0] cpu_sp,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          busy,
  output logic          done,
  output logic          halted,
  output logic [31:0]   new_pc,
  output logic [15:0]   new_sr,
  output logic [AW-1:0] new_sp
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
  localparam logic [AW-1:0]    STEP2    = AW'(2);
  localparam logic [AW-1:0]    STEP4    = AW'(4);

  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    sp_r, fa_r;
  logic [31:0]      pc_r;
  logic [15:0]      sr_r, wd_r, vhi_r;
  logic             fw_r, fb_r, fi_r;
  logic [15:0]      ssw;

  logic [IDX_W-1:0] sel_idx  [2];
  wkind_e           sel_kind [2];
  logic [15:0]      sel_data [2];
  logic [AW-1:0]    sp_after, next_addr;
  logic             working, fail;

  berr_ssw_enc u_ssw (
    .is_write (fw_r),
    .is_byte  (fb_r),
    .addr_b0  (fa_r[0]),
    .is_ifetch(fi_r),
    .ssw      (ssw)
  );

  // slot 0 describes the word in flight, slot 1 the word to issue next
  assign sel_idx[0] = idx;
  assign sel_idx[1] = (st == S_PUSH) ? idx + IDX_W'(1) : '0;

  for (genvar g = 0; g < 2; g++) begin : g_word
    berr_frame_word #(.FMT_VEC(FMT_VEC)) u_word (
      .idx  (sel_idx[g]),
      .ssw  (ssw),
      .wdata(wd_r),
      .faddr(32'(fa_r)),
      .pc   (pc_r),
      .sr   (sr_r),
      .kind (sel_kind[g]),
      .data (sel_data[g])
    );
  end

  always_comb begin
    sp_after = sp_r;
    if (st == S_PUSH) begin
      if (sel_kind[0] == WK_LLO)      sp_after = sp_r - STEP4;
      else if (sel_kind[0] == WK_SGL) sp_after = sp_r - STEP2;
    end
    next_addr = sp_after - ((sel_kind[1] == WK_LHI) ? STEP4 : STEP2);
  end

  assign working = (st == S_VHI) || (st == S_VLO) || (st == S_PUSH);
  assign fail    = working && (flt_valid || (mem_req && mem_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;   idx <= '0;
      sp_r <= '0;     fa_r <= '0;   pc_r <= '0;
      sr_r <= '0;     wd_r <= '0;   vhi_r <= '0;
      fw_r <= 1'b0;   fb_r <= 1'b0; fi_r <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      busy <= 1'b0;   done <= 1'b0; halted <= 1'b0;
      new_pc <= '0;   new_sr <= '0; new_sp <= '0;
    end else begin
      done <= 1'b0;
      if (fail) begin
        st      <= S_HALT;
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        busy    <= 1'b0;
        halted  <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (flt_valid) begin
            fw_r <= flt_write; fb_r <= flt_byte; fi_r <= flt_ifetch;
            fa_r <= flt_addr;  wd_r <= flt_wdata;
            pc_r <= cpu_pc;    sr_r <= cpu_sr;   sp_r <= cpu_sp;
            st       <= S_VHI;
            busy     <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= VEC_ADDR;
          end
          S_VHI: if (mem_ack) begin
            vhi_r    <= mem_rdata;
            mem_addr <= VEC_ADDR + STEP2;
            st       <= S_VLO;
          end
          S_VLO: if (mem_ack) begin
            new_pc    <= {vhi_r, mem_rdata};
            idx       <= '0;
            mem_we    <= 1'b1;
            mem_addr  <= next_addr;
            mem_wdata <= sel_data[1];
            st        <= S_PUSH;
          end
          S_PUSH: if (mem_ack) begin
            sp_r <= sp_after;
            if (idx == LAST_IDX) begin
              mem_req <= 1'b0;
              mem_we  <= 1'b0;
              busy    <= 1'b0;
              done    <= 1'b1;
              new_sp  <= sp_after;
              new_sr  <= sr_r | SUP_MASK;
              st      <= S_IDLE;
            end else begin
              idx       <= idx + IDX_W'(1);
              mem_addr  <= next_addr;
              mem_wdata <= sel_data[1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // request held unchanged until it is answered
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !mem_err && !flt_valid |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // all accesses are word aligned
  assert_align_R3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  // reads only ever target the two vector words
  assert_vecread_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> (mem_addr == VEC_ADDR) || (mem_addr == VEC_ADDR + STEP2));

  assert_errhalt_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_err |=> halted && !mem_req);

  assert_nested_R11: assert property (@(posedge clk) disable iff (rst)
    busy && flt_valid |=> halted);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !mem_req && !done);

  assert_donesr_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> new_sr[13] && !mem_req && !busy);
endmodule

// File: tb/berr_frame_seq_tb.sv
`timescale 1ns/1ps
module berr_frame_seq_tb_top;
  localparam int AW = 24;

  typedef struct packed {
    logic          w;
    logic          b;
    logic          i;
    logic [AW-1:0] fa;
    logic [15:0]   wd;
    logic [31:0]   pc;
    logic [15:0]   sr;
    logic [AW-1:0] sp;
    logic [31:0]   vec;
    logic [3:0]    wt;
  } case_t;

  localparam int NCASES = 4;
  localparam case_t CASES [NCASES] = '{
    '{1'b1, 1'b0, 1'b0, 24'h123456, 16'hBEEF, 32'h0000_1000, 16'h0004, 24'h008000, 32'h00AB_CDE0, 4'd0},
    '{1'b0, 1'b1, 1'b0, 24'hFF0001, 16'h0000, 32'h0040_2222, 16'h2715, 24'h006000, 32'h0012_3400, 4'd2},
    '{1'b0, 1'b0, 1'b1, 24'h000F0E, 16'h1234, 32'hCAFE_0002, 16'h8000, 24'h004000, 32'hFFFF_0000, 4'd1},
    '{1'b1, 1'b1, 1'b0, 24'h777773, 16'h00A5, 32'h0000_0000, 16'hFFFF, 24'h003002, 32'h0000_0400, 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flt_valid = 1'b0, flt_write = 1'b0, flt_byte = 1'b0, flt_ifetch = 1'b0;
  logic [AW-1:0] flt_addr = '0, cpu_sp = '0;
  logic [15:0]   flt_wdata = '0, cpu_sr = '0;
  logic [31:0]   cpu_pc = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          mem_ack = 1'b0, mem_err = 1'b0;
  logic          busy, done, halted;
  logic [31:0]   new_pc;
  logic [15:0]   new_sr;
  logic [AW-1:0] new_sp;

  int checks = 0;
  int errors = 0;

  // memory model state
  logic [15:0]   smem [logic [AW-1:0]];
  int            wait_cfg = 0, wcnt = 0;
  int            wr_count = 0, rd_count = 0, oob = 0;
  int            err_wr_idx = -1;
  bit            err_rd = 1'b0;
  logic [AW-1:0] lo_bound = '0, hi_bound = '0;
  logic [AW-1:0] first_wr [2];

  always #2.5 clk = ~clk;

  berr_frame_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst),
    .flt_valid(flt_valid), .flt_write(flt_write), .flt_byte(flt_byte),
    .flt_ifetch(flt_ifetch), .flt_addr(flt_addr), .flt_wdata(flt_wdata),
    .cpu_pc(cpu_pc), .cpu_sr(cpu_sr), .cpu_sp(cpu_sp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .busy(busy), .done(done), .halted(halted),
    .new_pc(new_pc), .new_sr(new_sr), .new_sp(new_sp)
  );

  // responder: answers on the falling edge, consumed at the next rising edge
  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (!rst && mem_req) begin
      if (wcnt < wait_cfg) begin
        wcnt++;
      end else begin
        wcnt = 0;
        if (mem_we) begin
          if (wr_count == err_wr_idx) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            smem[mem_addr] = mem_wdata;
            if (wr_count < 2) first_wr[wr_count] = mem_addr;
            if (mem_addr < lo_bound || mem_addr > hi_bound || mem_addr[0]) oob++;
            wr_count++;
          end
        end else begin
          if (err_rd) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            mem_rdata = smem.exists(mem_addr) ? smem[mem_addr] : 16'h0000;
            rd_count++;
          end
        end
      end
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input logic [AW-1:0] a);
    return smem.exists(a) ? smem[a] : 16'hDEAD;
  endfunction

  function automatic logic [15:0] exp_ssw(input case_t c);
    return 16'((c.w << 8) | (c.b << 9) | (c.fa[0] << 10) | (c.i << 13));
  endfunction

  function automatic logic [15:0] exp_word(input case_t c, input int off);
    logic [31:0] fa32;
    fa32 = 32'(c.fa);
    case (off)
      0:  return c.sr;
      2:  return c.pc[31:16];
      4:  return c.pc[15:0];
      6:  return 16'h8002;
      8:  return exp_ssw(c);
      10: return fa32[31:16];
      12: return fa32[15:0];
      16: return c.wd;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic prep(input case_t c);
    smem.delete();
    smem[24'd8]  = c.vec[31:16];
    smem[24'd10] = c.vec[15:0];
    wr_count = 0; rd_count = 0; oob = 0; wcnt = 0;
    wait_cfg = int'(c.wt);
    lo_bound = c.sp - 24'd58;
    hi_bound = c.sp - 24'd2;
    first_wr[0] = '0; first_wr[1] = '0;
  endtask

  // pulse a fault report; returns after the sampling edge, at the falling edge
  task automatic launch(input case_t c);
    @(negedge clk);
    flt_write = c.w; flt_byte = c.b; flt_ifetch = c.i;
    flt_addr = c.fa; flt_wdata = c.wd;
    cpu_pc = c.pc; cpu_sr = c.sr; cpu_sp = c.sp;
    flt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flt_valid = 1'b0;
  endtask

  task automatic wait_end(output int k);
    k = 0;
    while (!done && !halted && k < 2000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_case(input case_t c, input int n);
    int k;
    int bad;
    prep(c);
    launch(c);
    wait_end(k);
    chk(done && !halted, "R8", $sformatf("case %0d done", n), {62'd0, halted, done}, 64'd1);
    chk(k == 31 * (int'(c.wt) + 1), "R8", $sformatf("case %0d cycles to done", n),
        64'(k), 64'(31 * (int'(c.wt) + 1)));
    chk(new_pc == c.vec, "R2", "new_pc", 64'(new_pc), 64'(c.vec));
    chk(rd_count == 2, "R2", "vector reads", 64'(rd_count), 64'd2);
    chk(new_sp == c.sp - 24'd58, "R3", "new_sp", 64'(new_sp), 64'(c.sp - 24'd58));
    chk(wr_count == 29 && oob == 0, "R3", "write count/range", 64'(wr_count * 1000 + oob), 64'd29000);
    chk(first_wr[0] == c.sp - 24'd4 && first_wr[1] == c.sp - 24'd2, "R6", "long push order",
        {8'd0, first_wr[0], 8'd0, first_wr[1]}, {8'd0, c.sp - 24'd4, 8'd0, c.sp - 24'd2});
    chk(new_sr == (c.sr | 16'h2000), "R7", "new_sr", 64'(new_sr), 64'(c.sr | 16'h2000));
    chk(rd(new_sp) == c.sr, "R7", "stacked SR unmodified", 64'(rd(new_sp)), 64'(c.sr));
    chk(rd(new_sp + 24'd8) == exp_ssw(c), "R5", "status word", 64'(rd(new_sp + 24'd8)), 64'(exp_ssw(c)));
    bad = 0;
    for (int off = 0; off < 58; off += 2) begin
      if (rd(new_sp + AW'(off)) !== exp_word(c, off)) begin
        bad++;
        $display("  mismatch at +%0d: %0h vs %0h", off, rd(new_sp + AW'(off)), exp_word(c, off));
      end
    end
    chk(bad == 0, "R4", $sformatf("case %0d frame layout", n), 64'(bad), 64'd0);
    @(negedge clk);
    chk(!done && !mem_req && !busy, "R8", "done is a single pulse", {61'd0, busy, mem_req, done}, 64'd0);
  endtask

  initial begin
    int k;
    int wsave;
    do_reset();
    @(negedge clk);
    chk(!mem_req && !done && !busy && !halted, "R1", "reset state",
        {60'd0, halted, busy, done, mem_req}, 64'd0);

    for (int n = 0; n < NCASES; n++) run_case(CASES[n], n);

    // error on the sixth frame write
    prep(CASES[0]);
    err_wr_idx = 5;
    launch(CASES[0]);
    wait_end(k);
    err_wr_idx = -1;
    chk(halted && !done, "R9", "halt on write error", {62'd0, done, halted}, 64'd1);
    chk(!mem_req && wr_count == 5, "R9", "writes stop at fault", 64'(wr_count), 64'd5);
    repeat (3) @(negedge clk);
    chk(halted && !mem_req, "R9", "halt persists", {62'd0, mem_req, halted}, 64'd1);

    // new report while halted
    wsave = wr_count;
    launch(CASES[1]);
    repeat (4) @(negedge clk);
    chk(halted && !mem_req && !done && wr_count == wsave && rd_count == 2, "R12",
        "fault ignored while halted", 64'(wr_count), 64'(wsave));

    do_reset();
    @(negedge clk);
    chk(!halted && !mem_req && !busy, "R1", "reset clears halt", {61'd0, busy, mem_req, halted}, 64'd0);

    // error on the vector read
    prep(CASES[2]);
    err_rd = 1'b1;
    launch(CASES[2]);
    wait_end(k);
    err_rd = 1'b0;
    chk(halted && !done && wr_count == 0, "R10", "halt on vector read error",
        64'(wr_count), 64'd0);
    do_reset();

    // nested fault during the push phase
    prep(CASES[0]);
    launch(CASES[0]);
    repeat (6) @(negedge clk);
    chk(busy && !halted, "R11", "busy before nested fault", {62'd0, halted, busy}, 64'd2);
    flt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flt_valid = 1'b0;
    chk(halted && !mem_req && !busy, "R11", "nested fault halts", {61'd0, busy, mem_req, halted}, 64'd1);
    wsave = wr_count;
    repeat (40) @(negedge clk);
    chk(!done && wr_count == wsave && wr_count < 29, "R11", "no further writes",
        64'(wr_count), 64'(wsave));

    do_reset();
    run_case(CASES[3], 3);

    finish_up();
  end
endmodule